// File: doc/BRIEF.md
# Indirect Register Write Sequencer

This block loads a block of configuration bytes into a demodulator that hides its internal registers behind three bus-visible ones: a page register at 0xA6, a data port at 0xA7 and a command register at 0xA8. The block does not drive bus pins. It sends byte-level transaction commands (start with address, write byte, read byte, stop) to an external I2C master and reads back one response per command. A single `start` pulse captures the configuration bytes. The block then polls the device until it is ready, selects page 0, bursts the bytes into the data port and issues the write command (0x03). It polls for completion and finally reads the data port back to check that the write landed.

Any failure aborts the current attempt. A failure is a missing acknowledge, a poll that runs out of iterations, or a read-back mismatch. The block then moves to the next of three candidate device addresses. When all candidates fail, it repeats the whole pass over the candidates, up to a set number of outer attempts. A one-cycle `done` pulse reports the result, and on success `win_idx` gives the candidate that worked.

The command channel toward the bus master is valid/ready. The block holds `cmd_valid`, `cmd_op` and `cmd_data` unchanged until the master accepts with `cmd_ready`, so the master may stall for any number of cycles. The block never has more than one command outstanding: it waits for that command's response before it raises `cmd_valid` again. The response channel has no back-pressure. `rsp_valid` is a single-cycle strobe, and the block accepts it whenever it arrives.

Top module: `indirect_wr_seq`

## Requirements
- R1: While reset is applied and after it is released with no `start`, `busy`, `done` and `cmd_valid` are low.
- R2: Once raised, `cmd_valid` stays high and `cmd_op`/`cmd_data` stay stable until `cmd_ready` is sampled high. No new command is offered between an accepted command and its `rsp_valid` strobe.
- R3: Opcodes are 0 = start+address, 1 = write byte, 2 = read byte and 3 = stop; read and stop carry data 0x00. A register write is start (address<<1), write of the register number, write of each data byte, then stop. A register read is start (address<<1), write of the register number, start ((address<<1)|1), read, then stop.
- R4: Each attempt opens with a ready poll that reads 0xA2, then 0xA8, then 0xA4. The device counts as ready when the 0xA8 byte is 0x00; otherwise the three reads repeat.
- R5: Programming writes 0x00 to 0xA6, then all NB bytes captured at `start` to 0xA7 in one transaction (byte 0, bits 7:0 of `cfg_bytes`, first), then 0x03 to 0xA8.
- R6: The completion poll reads 0xA8 then 0xA2 and repeats until the 0xA8 byte is 0x00.
- R7: A poll that finds the device busy on POLL_MAX consecutive iterations fails the attempt.
- R8: Verification writes 0x00 to 0xA6 and reads 0xA7. The attempt succeeds only if the byte equals configuration byte 0; a mismatch fails it.
- R9: A start or write-byte command that is not acknowledged is followed at once by a stop, and the attempt fails.
- R10: Candidate addresses are tried in index order (default 0x10, 0x3F, 0x7F). The first success ends the run with `ok` high and `win_idx` set to that index.
- R11: After every candidate has failed, the pass over the candidates repeats, up to ATTEMPTS passes in total. If all of them fail, `done` pulses with `ok` low.
- R12: `done` is high for exactly one cycle, and `ok`/`win_idx` hold their value from then until the next `start`. A `start` that arrives while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a programming run (ignored while busy) |
| cfg_bytes | input | NB*8 | Configuration bytes, byte 0 in bits 7:0, captured on start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Run succeeded |
| win_idx | output | IW | Index of the candidate address that succeeded |
| cmd_valid | output | 1 | Command offered to the bus master |
| cmd_ready | input | 1 | Bus master accepts the command |
| cmd_op | output | 2 | Command opcode |
| cmd_data | output | 8 | Address byte or data byte for the command |
| rsp_valid | input | 1 | Response strobe, one per accepted command |
| rsp_ack | input | 1 | Byte was acknowledged |
| rsp_data | input | 8 | Byte returned by a read command |

## Verification
A behavioural device model answers every command. It tracks which candidate addresses are present, how many busy reads 0xA8 returns before and after the write command, the value 0xA7 returns, and an optional forced missing acknowledge. Every accepted command is compared in order with a stream predicted from the requirements.

The stimulus patterns each expose a different fault. A clean first-candidate run checks basic ordering and byte order. Busy polls combined with a stalling master separate the two poll loops and exercise the hold rule. Absent first or first two addresses confirm the candidate order and `win_idx`. A poll that stays busy exactly POLL_MAX times, followed by success on the second pass, pins down the iteration limit. A permanent read-back mismatch must exhaust all passes. A missing acknowledge in the middle of the burst must cut the transaction short with a stop.

// File: rtl/isw_pkg.sv
package isw_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  localparam logic [7:0] RG_STAT = 8'hA2;
  localparam logic [7:0] RG_LOCK = 8'hA4;
  localparam logic [7:0] RG_PAGE = 8'hA6;
  localparam logic [7:0] RG_DATA = 8'hA7;
  localparam logic [7:0] RG_CMD  = 8'hA8;
  localparam logic [7:0] CMD_WR  = 8'h03;

endpackage

// File: rtl/isw_xact.sv
// One register transaction (write of n bytes or single-byte read) on the
// byte-level command channel, one command outstanding at a time.
module isw_xact
  import isw_pkg::*;
#(
  parameter int MAXB = 4,
  localparam int BW = $clog2(MAXB + 1),
  localparam int PW = $clog2(MAXB + 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          rd,
  input  logic [6:0]    dev,
  input  logic [7:0]    regad,
  input  logic [BW-1:0] nbytes,
  output logic [BW-1:0] byte_idx,
  input  logic [7:0]    byte_in,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_data,
  input  logic          rsp_valid,
  input  logic          rsp_ack,
  input  logic [7:0]    rsp_data,
  output logic          done,
  output logic          nack,
  output logic [7:0]    rd_byte
);

  typedef enum logic [1:0] {XS_IDLE, XS_ISSUE, XS_WAIT} xst_e;

  xst_e          st;
  logic          rd_q, stop_q;
  logic [6:0]    dev_q;
  logic [7:0]    reg_q;
  logic [BW-1:0] nb_q;
  logic [PW-1:0] pos;
  bus_op_e       op;
  logic [7:0]    data;
  logic [PW-1:0] wr_end;

  assign wr_end   = PW'(nb_q) + PW'(2);
  assign byte_idx = BW'(pos - PW'(2));

  always_comb begin
    op   = OP_STOP;
    data = 8'h00;
    if (stop_q) begin
      op = OP_STOP;
    end else if (rd_q) begin
      case (pos)
        PW'(0): begin op = OP_START; data = {dev_q, 1'b0}; end
        PW'(1): begin op = OP_WRITE; data = reg_q; end
        PW'(2): begin op = OP_START; data = {dev_q, 1'b1}; end
        PW'(3): op = OP_READ;
        default: op = OP_STOP;
      endcase
    end else if (pos == PW'(0)) begin
      op = OP_START; data = {dev_q, 1'b0};
    end else if (pos == PW'(1)) begin
      op = OP_WRITE; data = reg_q;
    end else if (pos < wr_end) begin
      op = OP_WRITE; data = byte_in;
    end
  end

  assign cmd_valid = (st == XS_ISSUE);
  assign cmd_op    = op;
  assign cmd_data  = data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= XS_IDLE;
      rd_q    <= 1'b0;
      stop_q  <= 1'b0;
      dev_q   <= '0;
      reg_q   <= '0;
      nb_q    <= '0;
      pos     <= '0;
      done    <= 1'b0;
      nack    <= 1'b0;
      rd_byte <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        XS_IDLE: if (go) begin
          rd_q   <= rd;
          dev_q  <= dev;
          reg_q  <= regad;
          nb_q   <= nbytes;
          pos    <= '0;
          stop_q <= 1'b0;
          nack   <= 1'b0;
          st     <= XS_ISSUE;
        end
        XS_ISSUE: if (cmd_ready) st <= XS_WAIT;
        XS_WAIT: if (rsp_valid) begin
          if (op == OP_STOP) begin
            st   <= XS_IDLE;
            done <= 1'b1;
          end else begin
            st <= XS_ISSUE;
            if (op == OP_READ) rd_byte <= rsp_data;
            if (op != OP_READ && !rsp_ack) begin
              stop_q <= 1'b1;
              nack   <= 1'b1;
            end else begin
              pos <= pos + PW'(1);
            end
          end
        end
        default: st <= XS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/isw_seq.sv
// Phase sequencer: ready poll, page, burst, command, completion poll,
// verify, with candidate and outer-attempt retry.
module isw_seq
  import isw_pkg::*;
#(
  parameter int NB = 4,
  parameter int NCAND = 3,
  parameter logic [NCAND-1:0][6:0] CAND = {7'h7F, 7'h3F, 7'h10},
  parameter int ATTEMPTS = 3,
  parameter int POLL_MAX = 8,
  localparam int IW  = (NCAND > 1) ? $clog2(NCAND) : 1,
  localparam int BW  = $clog2(NB + 1),
  localparam int BIW = (NB > 1) ? $clog2(NB) : 1,
  localparam int AW  = $clog2(ATTEMPTS + 1),
  localparam int PLW = $clog2(POLL_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NB*8-1:0] cfg,
  output logic          x_go,
  output logic          x_rd,
  output logic [6:0]    x_dev,
  output logic [7:0]    x_reg,
  output logic [BW-1:0] x_nbytes,
  input  logic [BW-1:0] x_idx,
  output logic [7:0]    x_byte,
  input  logic          x_done,
  input  logic          x_nack,
  input  logic [7:0]    x_rdata,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic [IW-1:0] win_idx
);

  typedef enum logic [3:0] {
    PH_IDLE, PH_RA2, PH_RA8, PH_RA4, PH_PAGE, PH_BURST, PH_CMD,
    PH_CA8, PH_CA2, PH_VPAGE, PH_VRD
  } ph_e;

  ph_e            ph, nxt;
  logic           launched, a8_busy;
  logic [7:0]     cfg_q [NB];
  logic [IW-1:0]  cand;
  logic [AW-1:0]  att;
  logic [PLW-1:0] poll;
  logic           fail, pass, poll_inc, poll_clr, poll_last;

  assign busy      = (ph != PH_IDLE);
  assign x_go      = busy && !launched;
  assign x_dev     = CAND[cand];
  assign poll_last = (poll == PLW'(POLL_MAX - 1));

  always_comb begin
    x_rd     = 1'b1;
    x_reg    = RG_STAT;
    x_nbytes = BW'(0);
    x_byte   = 8'h00;
    case (ph)
      PH_RA2, PH_CA2: x_reg = RG_STAT;
      PH_RA8, PH_CA8: x_reg = RG_CMD;
      PH_RA4:         x_reg = RG_LOCK;
      PH_VRD:         x_reg = RG_DATA;
      PH_PAGE, PH_VPAGE: begin
        x_rd = 1'b0; x_reg = RG_PAGE; x_nbytes = BW'(1); x_byte = 8'h00;
      end
      PH_BURST: begin
        x_rd = 1'b0; x_reg = RG_DATA; x_nbytes = BW'(NB);
        x_byte = cfg_q[BIW'(x_idx)];
      end
      PH_CMD: begin
        x_rd = 1'b0; x_reg = RG_CMD; x_nbytes = BW'(1); x_byte = CMD_WR;
      end
      default: ;
    endcase
  end

  always_comb begin
    nxt = ph; fail = 1'b0; pass = 1'b0; poll_inc = 1'b0; poll_clr = 1'b0;
    if (x_done) begin
      if (x_nack) fail = 1'b1;
      else begin
        case (ph)
          PH_RA2:   nxt = PH_RA8;
          PH_RA8:   nxt = PH_RA4;
          PH_RA4:
            if (!a8_busy) nxt = PH_PAGE;
            else if (poll_last) fail = 1'b1;
            else begin nxt = PH_RA2; poll_inc = 1'b1; end
          PH_PAGE:  nxt = PH_BURST;
          PH_BURST: nxt = PH_CMD;
          PH_CMD:   begin nxt = PH_CA8; poll_clr = 1'b1; end
          PH_CA8:   nxt = PH_CA2;
          PH_CA2:
            if (!a8_busy) nxt = PH_VPAGE;
            else if (poll_last) fail = 1'b1;
            else begin nxt = PH_CA8; poll_inc = 1'b1; end
          PH_VPAGE: nxt = PH_VRD;
          PH_VRD:
            if (x_rdata == cfg_q[0]) pass = 1'b1;
            else fail = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      launched <= 1'b0;
      a8_busy  <= 1'b0;
      cand     <= '0;
      att      <= '0;
      poll     <= '0;
      done     <= 1'b0;
      ok       <= 1'b0;
      win_idx  <= '0;
      for (int i = 0; i < NB; i++) cfg_q[i] <= '0;
    end else begin
      done <= 1'b0;
      if (x_done && (ph == PH_RA8 || ph == PH_CA8))
        a8_busy <= (x_rdata != 8'h00);
      if (ph == PH_IDLE) begin
        if (start) begin
          for (int i = 0; i < NB; i++) cfg_q[i] <= cfg[i*8 +: 8];
          cand     <= '0;
          att      <= '0;
          poll     <= '0;
          ok       <= 1'b0;
          launched <= 1'b0;
          ph       <= PH_RA2;
        end
      end else begin
        if (x_go) launched <= 1'b1;
        if (pass) begin
          ph      <= PH_IDLE;
          done    <= 1'b1;
          ok      <= 1'b1;
          win_idx <= cand;
        end else if (fail) begin
          poll     <= '0;
          launched <= 1'b0;
          if (cand == IW'(NCAND - 1)) begin
            cand <= '0;
            if (att == AW'(ATTEMPTS - 1)) begin
              ph   <= PH_IDLE;
              done <= 1'b1;
              ok   <= 1'b0;
            end else begin
              att <= att + AW'(1);
              ph  <= PH_RA2;
            end
          end else begin
            cand <= cand + IW'(1);
            ph   <= PH_RA2;
          end
        end else if (x_done) begin
          ph       <= nxt;
          launched <= 1'b0;
          if (poll_clr) poll <= '0;
          else if (poll_inc) poll <= poll + PLW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/indirect_wr_seq.sv
module indirect_wr_seq
  import isw_pkg::*;
#(
  parameter int NB = 4,
  parameter int NCAND = 3,
  parameter logic [NCAND-1:0][6:0] CAND = {7'h7F, 7'h3F, 7'h10},
  parameter int ATTEMPTS = 3,
  parameter int POLL_MAX = 8,
  localparam int IW = (NCAND > 1) ? $clog2(NCAND) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NB*8-1:0] cfg_bytes,
  output logic            busy,
  output logic            done,
  output logic            ok,
  output logic [IW-1:0]   win_idx,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [1:0]      cmd_op,
  output logic [7:0]      cmd_data,
  input  logic            rsp_valid,
  input  logic            rsp_ack,
  input  logic [7:0]      rsp_data
);

  localparam int BW = $clog2(NB + 1);

  logic          x_go, x_rd, x_done, x_nack;
  logic [6:0]    x_dev;
  logic [7:0]    x_reg, x_byte, x_rdata;
  logic [BW-1:0] x_nbytes, x_idx;

  isw_seq #(
    .NB(NB), .NCAND(NCAND), .CAND(CAND),
    .ATTEMPTS(ATTEMPTS), .POLL_MAX(POLL_MAX)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg_bytes),
    .x_go(x_go), .x_rd(x_rd), .x_dev(x_dev), .x_reg(x_reg),
    .x_nbytes(x_nbytes), .x_idx(x_idx), .x_byte(x_byte),
    .x_done(x_done), .x_nack(x_nack), .x_rdata(x_rdata),
    .busy(busy), .done(done), .ok(ok), .win_idx(win_idx)
  );

  isw_xact #(.MAXB(NB)) u_xact (
    .clk(clk), .rst_n(rst_n), .go(x_go), .rd(x_rd), .dev(x_dev),
    .regad(x_reg), .nbytes(x_nbytes), .byte_idx(x_idx), .byte_in(x_byte),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rsp_data(rsp_data), .done(x_done), .nack(x_nack), .rd_byte(x_rdata)
  );

endmodule

// File: rtl/indirect_wr_seq_chk.sv
module indirect_wr_seq_chk
  import isw_pkg::*;
#(
  parameter int NCAND = 3,
  localparam int IW = (NCAND > 1) ? $clog2(NCAND) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          ok,
  input logic [IW-1:0] win_idx,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [7:0]    cmd_data,
  input logic          rsp_valid,
  input logic          rsp_ack
);

  logic [1:0] last_op;
  logic       outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_op     <= 2'd3;
      outstanding <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        last_op     <= cmd_op;
        outstanding <= 1'b1;
      end else if (rsp_valid) begin
        outstanding <= 1'b0;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid); // R1

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data)); // R2

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !cmd_valid); // R2

  AST_ZERO_DATA_RD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 2'd2 || cmd_op == 2'd3) |-> cmd_data == 8'h00); // R3

  AST_END_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> last_op == 2'd3 && !outstanding); // R3

  AST_STOP_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ack && (last_op == 2'd0 || last_op == 2'd1)
      |=> cmd_valid && cmd_op == 2'd3); // R9

  AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> int'(win_idx) < NCAND); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

endmodule

bind indirect_wr_seq indirect_wr_seq_chk #(.NCAND(NCAND)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ok(ok),
  .win_idx(win_idx), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
  .rsp_ack(rsp_ack)
);

// File: tb/sim_indirect_wr_seq.sv
module sim_indirect_wr_seq;

  localparam int NB = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [NB*8-1:0] cfg_v = '0;
  logic            busy, done, ok;
  logic [1:0]      win;
  logic            cmd_valid, cmd_ready = 1'b0;
  logic [1:0]      cmd_op;
  logic [7:0]      cmd_data;
  logic            rsp_valid = 1'b0, rsp_ack = 1'b0;
  logic [7:0]      rsp_data = 8'h00;

  indirect_wr_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_bytes(cfg_v),
    .busy(busy), .done(done), .ok(ok), .win_idx(win),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  logic [9:0] expq[$];

  // behavioural device and bus-master model
  logic [2:0] present = 3'b000;
  int         busy_left = 0, cmp_busy = 0, nack_at = -1, cmd_count = 0, cyc = 0;
  logic [7:0] a7_val = 8'h00;
  bit         bp = 0;
  bit         pend = 0, pend_ack = 0, reg_phase = 0;
  logic [7:0] pend_data = 8'h00, cur_reg = 8'h00;

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_present(input logic [6:0] a);
    return (a == 7'h10 && present[0]) || (a == 7'h3F && present[1]) ||
           (a == 7'h7F && present[2]);
  endfunction

  task automatic accept();
    logic [9:0] got;
    logic [9:0] e;
    bit ack;
    logic [7:0] d;
    got = {cmd_op, cmd_data};
    if (expq.size() == 0) chk(0, "R3", "unexpected command", got, 0);
    else begin
      e = expq.pop_front();
      chk(got == e, "R3", "command stream", got, e);
    end
    ack = 1; d = 8'h00;
    case (cmd_op)
      2'd0: begin ack = is_present(cmd_data[7:1]); reg_phase = !cmd_data[0]; end
      2'd1: begin
        if (reg_phase) begin cur_reg = cmd_data; reg_phase = 0; end
        else if (cur_reg == 8'hA8 && cmd_data == 8'h03) busy_left = cmp_busy;
      end
      2'd2: begin
        if (cur_reg == 8'hA8) begin
          if (busy_left > 0) begin d = 8'h01; busy_left--; end
        end else if (cur_reg == 8'hA7) d = a7_val;
        else d = 8'h5A;
      end
      default: ;
    endcase
    if (cmd_count == nack_at) ack = 0;
    cmd_count++;
    pend = 1; pend_ack = ack; pend_data = d;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      rsp_valid = 0; pend = 0; cmd_ready = 0;
    end else begin
      rsp_valid = pend; rsp_ack = pend_ack; rsp_data = pend_data; pend = 0;
      cmd_ready = bp ? (cyc % 3 != 0) : 1'b1;
      if (cmd_valid && cmd_ready) accept();
    end
  end

  // expected-stream builders
  task automatic push(input logic [1:0] op, input logic [7:0] d);
    expq.push_back({op, d});
  endtask
  task automatic e_rd(input logic [6:0] a, input logic [7:0] r);
    push(2'd0, {a, 1'b0}); push(2'd1, r); push(2'd0, {a, 1'b1});
    push(2'd2, 8'h00); push(2'd3, 8'h00);
  endtask
  task automatic e_wr(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d);
    push(2'd0, {a, 1'b0}); push(2'd1, r); push(2'd1, d); push(2'd3, 8'h00);
  endtask
  task automatic e_poll(input logic [6:0] a);
    e_rd(a, 8'hA2); e_rd(a, 8'hA8); e_rd(a, 8'hA4);
  endtask
  task automatic e_abs(input logic [6:0] a);
    push(2'd0, {a, 1'b0}); push(2'd3, 8'h00);
  endtask
  task automatic e_att(input logic [6:0] a, input int rb, input int cb);
    for (int i = 0; i <= rb; i++) e_poll(a);
    e_wr(a, 8'hA6, 8'h00);
    push(2'd0, {a, 1'b0}); push(2'd1, 8'hA7);
    for (int i = 0; i < NB; i++) push(2'd1, cfg_v[i*8 +: 8]);
    push(2'd3, 8'h00);
    e_wr(a, 8'hA8, 8'h03);
    for (int i = 0; i <= cb; i++) begin e_rd(a, 8'hA8); e_rd(a, 8'hA2); end
    e_wr(a, 8'hA6, 8'h00);
    e_rd(a, 8'hA7);
  endtask

  task automatic setup(input logic [2:0] pr, input int rb, input int cb,
                       input logic [31:0] cfg, input bit good_rb,
                       input int nk, input bit stall);
    present = pr; busy_left = rb; cmp_busy = cb; cfg_v = cfg;
    a7_val = good_rb ? cfg[7:0] : ~cfg[7:0];
    nack_at = nk; bp = stall; cmd_count = 0; expq.delete();
  endtask

  task automatic run(input string req, input bit exp_ok, input int exp_win,
                     input bit poke);
    int n;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      start = poke && (n == 20);
    end
    start = 0;
    chk(ok == exp_ok, req, "ok result", ok, exp_ok);
    if (exp_ok) chk(win == 2'(exp_win), req, "winning index", win, exp_win);
    chk(expq.size() == 0, req, "predicted commands left over", expq.size(), 0);
    @(negedge clk);
    chk(done == 0, "R12", "done width", done, 0);
    chk(busy == 0 && cmd_valid == 0, "R12", "idle after done", {busy, cmd_valid}, 0);
    chk(ok == exp_ok, "R12", "ok held", ok, exp_ok);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && cmd_valid == 0, "R1", "state in reset",
        {busy, done, cmd_valid}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && cmd_valid == 0, "R1", "idle after reset",
        {busy, done, cmd_valid}, 0);

    // R5 R8: clean run on candidate 0
    setup(3'b001, 0, 0, 32'h44332211, 1, -1, 0);
    e_att(7'h10, 0, 0);
    run("R5", 1, 0, 0);

    // R4 R6 R2: busy polls, stalling master, start poked mid-run (R12)
    setup(3'b001, 2, 3, 32'hDEADBEEF, 1, -1, 1);
    e_att(7'h10, 2, 3);
    run("R6", 1, 0, 1);

    // R10: first candidate absent
    setup(3'b010, 0, 0, 32'h0A0B0C0D, 1, -1, 0);
    e_abs(7'h10); e_att(7'h3F, 0, 0);
    run("R10", 1, 1, 0);

    // R10: only the last candidate answers
    setup(3'b100, 0, 0, 32'h99887766, 1, -1, 0);
    e_abs(7'h10); e_abs(7'h3F); e_att(7'h7F, 0, 0);
    run("R10", 1, 2, 0);

    // R7 R11: ready poll busy for exactly POLL_MAX iterations, second pass wins
    setup(3'b001, 8, 0, 32'h13572468, 1, -1, 0);
    for (int i = 0; i < 8; i++) e_poll(7'h10);
    e_abs(7'h3F); e_abs(7'h7F);
    e_att(7'h10, 0, 0);
    run("R7", 1, 0, 0);

    // R8 R11: read-back always wrong, every pass fails
    setup(3'b001, 0, 0, 32'hCAFEF00D, 0, -1, 0);
    for (int p = 0; p < 3; p++) begin
      e_att(7'h10, 0, 0); e_abs(7'h3F); e_abs(7'h7F);
    end
    run("R11", 0, 0, 0);

    // R9: missing acknowledge on the second burst byte
    setup(3'b011, 0, 0, 32'h55AA33CC, 1, 22, 0);
    e_poll(7'h10);
    e_wr(7'h10, 8'hA6, 8'h00);
    push(2'd0, {7'h10, 1'b0}); push(2'd1, 8'hA7);
    push(2'd1, 8'hCC); push(2'd1, 8'h33); push(2'd3, 8'h00);
    e_att(7'h3F, 0, 0);
    run("R9", 1, 1, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule